// File: doc/BRIEF.md
# Enhanced parallel port cycle engine

This block turns host register accesses into byte-wide enhanced-parallel-port transfers on an external peripheral bus. The host sees a small register window. Offset 0 holds the output data byte, offset 1 returns peripheral status, and offset 2 holds the port control byte. Offset 3 runs a single address transfer and offset 4 runs a data transfer of 1, 2 or 4 bytes. A transfer is allowed only when the control byte selects the enhanced mode in the right direction. Otherwise writes are discarded and reads return all ones.

Each byte on the bus follows a fixed handshake. The engine pulls the address or data strobe low, with the write-enable line showing the direction. It holds the strobe until the peripheral raises its ready line, then releases the strobe and waits for ready to fall. Wide data accesses become a burst of byte transfers, lowest byte first. A byte that gets no answer within a cycle budget aborts the whole access and sets a sticky timeout flag. That flag shows in status bit 0 until software writes a 1 to that bit.

The host handshake is a request pulse accepted while `host_rdy` is high. `host_done` pulses for one cycle when the access has finished, with read data valid in the same cycle.

Top module: `epp_bridge`

## Requirements
- R1: After reset the control byte reads 0xCC, the data byte reads 0xFF, status bit 0 reads 0, both strobes are high and `host_rdy` is high.
- R2: A write to offset 3 or 4 runs bus transfers only when (control AND 0x2F) equals 0x04. Otherwise no strobe falls and the access completes without effect.
- R3: A read of offset 3 or 4 runs bus transfers only when (control AND 0x2F) equals 0x24. Otherwise no strobe falls and the read returns ones in the low 8, 16 or 32 bits for its width.
- R4: Offset 3 drives `adr_stb_n` and offset 4 drives `dat_stb_n`, never both at once. An offset-3 access is always exactly one byte, whatever `host_sz` says.
- R5: For an offset-4 access, `host_sz` 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. Bytes go out, or are placed in `host_rdata`, least significant first, and bits above the access width read 0.
- R6: During a transfer `bus_wr_n` is low for writes and high for reads, and `bus_oe` follows it. The strobe is released only after `per_rdy` has been seen high, and the next byte's strobe falls only after `per_rdy` has been seen low.
- R7: If `per_rdy` does not change within TMO_CYC cycles of a handshake phase starting, the access aborts. The timeout flag is set and the remaining bytes are not transferred. An aborted read returns the bytes captured so far, with ones in the untransferred bytes of its width. An abort in the strobe phase completes TMO_CYC+1 cycles after the accepting edge.
- R8: A status read returns {`stat_pins`, timeout flag}. Writing offset 1 with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag as it was.
- R9: A write to offset 0 whose low byte differs from the stored byte updates `dreg_o` and pulses `dreg_upd` once. An equal value gives no pulse.
- R10: Control writes are stored with bits 7:6 forced to 1. A write equal to the stored value after that forcing gives no `ctl_upd` pulse.
- R11: A control write that flips bit 5 (direction) first pulses `dir_upd` with the new `dir_o`. The control byte is applied, with a `ctl_upd` pulse, one cycle later.
- R12: `host_rdy` is low from the accepting edge until the cycle after `host_done`. `host_done` is a single-cycle pulse, and a strobe is never low while `host_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, taken when `host_rdy` is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 3 | Register offset |
| host_sz | input | 2 | Data width code for offset 4 |
| host_wdata | input | 32 | Write value |
| host_rdy | output | 1 | Engine idle, request accepted |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with `host_done` |
| stat_pins | input | 7 | Peripheral status lines for status bits 7:1 |
| dreg_o | output | 8 | Stored output data byte |
| dreg_upd | output | 1 | Data byte changed |
| ctl_o | output | 8 | Stored control byte |
| ctl_upd | output | 1 | Control byte changed |
| dir_o | output | 1 | Data direction, 1 = peripheral to host |
| dir_upd | output | 1 | Direction change notice |
| adr_stb_n | output | 1 | Address strobe, active low |
| dat_stb_n | output | 1 | Data strobe, active low |
| bus_wr_n | output | 1 | Low during write transfers |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| bus_dout | output | 8 | Byte driven to the peripheral |
| bus_din | input | 8 | Byte from the peripheral |
| per_rdy | input | 1 | Peripheral handshake, high = answered |

## Verification
The bench sweeps all 64 values of control bits 5:0 and checks that only the two exact mode patterns start transfers. A looser mask, for example one that ignores the select or strobe bits, would start cycles where none may run. Byte order is checked at every width against arithmetic shifts of the written value. This catches swapped lanes, wrong byte counts, or an offset-3 access that bursts.

Timeouts are forced in the strobe phase and in the release phase, and partway through a wide read. The bench checks that the tail bytes are skipped, that ones fill the missing bytes, and that the flag stays set until a write with bit 0 set. The abort latency is checked to the cycle. Redundant data and control writes, together with a direction flip, show whether pulses fire for unchanged values or in the wrong order.

// File: rtl/epp_pkg.sv
package epp_pkg;

  localparam int unsigned HOST_W = 32;
  localparam int unsigned LANES  = HOST_W / 8;

  localparam logic [7:0] MODE_MASK  = 8'h2F;
  localparam logic [7:0] MODE_WR    = 8'h04;
  localparam logic [7:0] MODE_RD    = 8'h24;
  localparam logic [7:0] CTL_FORCE  = 8'hC0;
  localparam logic [7:0] CTL_RESET  = 8'hCC;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR, ST_STB, ST_REL, ST_FIN
  } eng_st_t;

  // number of byte transfers for a width code
  function automatic logic [2:0] width_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // all-ones pattern covering the given byte count
  function automatic logic [HOST_W-1:0] ones_fill(input logic [2:0] nb);
    logic [HOST_W-1:0] v;
    v = '0;
    for (int b = 0; b < int'(LANES); b++)
      if (b < int'(nb)) v[b*8 +: 8] = 8'hFF;
    return v;
  endfunction

endpackage

// File: rtl/epp_mode_gate.sv
module epp_mode_gate
  import epp_pkg::*;
(
  input  logic [7:0] ctl,
  output logic       wr_ok,
  output logic       rd_ok
);
  assign wr_ok = (ctl & MODE_MASK) == MODE_WR;
  assign rd_ok = (ctl & MODE_MASK) == MODE_RD;
endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
  parameter int unsigned LIMIT = 2500,
  localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  output logic expired
);
  logic [TW-1:0] cnt;

  assign expired = run && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || step) cnt <= '0;
    else if (!expired)          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/epp_byte_lane.sv
module epp_byte_lane
  import epp_pkg::*;
#(
  localparam int unsigned IW = $clog2(LANES)
) (
  input  logic [HOST_W-1:0] wbuf,
  input  logic [HOST_W-1:0] rbuf,
  input  logic [IW-1:0]     idx,
  input  logic [7:0]        din,
  output logic [7:0]        wbyte,
  output logic [HOST_W-1:0] rmerged
);
  assign wbyte = wbuf[idx*8 +: 8];

  for (genvar b = 0; b < int'(LANES); b++) begin : g_lane
    assign rmerged[b*8 +: 8] = (idx == IW'(b)) ? din : rbuf[b*8 +: 8];
  end
endmodule

// File: rtl/epp_bridge.sv
module epp_bridge
  import epp_pkg::*;
#(
  parameter int unsigned TMO_CYC = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [2:0]        host_ofs,
  input  logic [1:0]        host_sz,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              host_rdy,
  output logic              host_done,
  output logic [HOST_W-1:0] host_rdata,
  input  logic [7:1]        stat_pins,
  output logic [7:0]        dreg_o,
  output logic              dreg_upd,
  output logic [7:0]        ctl_o,
  output logic              ctl_upd,
  output logic              dir_o,
  output logic              dir_upd,
  output logic              adr_stb_n,
  output logic              dat_stb_n,
  output logic              bus_wr_n,
  output logic              bus_oe,
  output logic [7:0]        bus_dout,
  input  logic [7:0]        bus_din,
  input  logic              per_rdy
);
  localparam int unsigned IW = $clog2(LANES);

  eng_st_t           st;
  logic [7:0]        ctl_q, dreg_q, pend_ctl;
  logic              tmo_q, is_adr, is_wr;
  logic [IW-1:0]     idx, last;
  logic [HOST_W-1:0] wbuf, rbuf, rmerged;
  logic              wr_ok, rd_ok, expired;

  // named events used by the checker
  logic acc, stb_on, xfer, step, tmo_evt, clr_evt;
  logic [7:0] ctl_new;
  logic [2:0] nb_req;

  assign acc     = host_req && (st == ST_IDLE);
  assign stb_on  = (st == ST_STB);
  assign xfer    = (st == ST_STB) || (st == ST_REL);
  assign step    = (stb_on && per_rdy) || ((st == ST_REL) && !per_rdy);
  assign tmo_evt = expired && !step;
  assign clr_evt = acc && host_wr && (host_ofs == 3'd1) && host_wdata[0];
  assign ctl_new = host_wdata[7:0] | CTL_FORCE;
  assign nb_req  = (host_ofs == 3'd3) ? 3'd1 : width_bytes(host_sz);

  epp_mode_gate gate_i (.ctl(ctl_q), .wr_ok(wr_ok), .rd_ok(rd_ok));

  epp_wait_timer #(.LIMIT(TMO_CYC)) tmr_i (
    .clk(clk), .rst_n(rst_n), .run(xfer), .step(step), .expired(expired)
  );

  epp_byte_lane lane_i (
    .wbuf(wbuf), .rbuf(rbuf), .idx(idx), .din(bus_din),
    .wbyte(bus_dout), .rmerged(rmerged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ctl_q    <= CTL_RESET;
      pend_ctl <= CTL_RESET;
      dreg_q   <= 8'hFF;
      dir_o    <= 1'b0;
      is_adr   <= 1'b0;
      is_wr    <= 1'b0;
      idx      <= '0;
      last     <= '0;
      wbuf     <= '0;
      rbuf     <= '0;
      dreg_upd <= 1'b0;
      ctl_upd  <= 1'b0;
      dir_upd  <= 1'b0;
    end else begin
      dreg_upd <= 1'b0;
      ctl_upd  <= 1'b0;
      dir_upd  <= 1'b0;
      case (st)
        ST_IDLE: if (acc) begin
          st   <= ST_FIN;
          rbuf <= '0;
          case (host_ofs)
            3'd0: if (host_wr) begin
              if (host_wdata[7:0] != dreg_q) begin
                dreg_q   <= host_wdata[7:0];
                dreg_upd <= 1'b1;
              end
            end else begin
              rbuf[7:0] <= ctl_q[5] ? bus_din : dreg_q;
            end
            3'd1: if (!host_wr) rbuf[7:0] <= {stat_pins, tmo_q};
            3'd2: if (host_wr) begin
              if (ctl_new != ctl_q) begin
                if (ctl_new[5] != ctl_q[5]) begin
                  st       <= ST_DIR;
                  pend_ctl <= ctl_new;
                  dir_o    <= ctl_new[5];
                  dir_upd  <= 1'b1;
                end else begin
                  ctl_q   <= ctl_new;
                  ctl_upd <= 1'b1;
                end
              end
            end else begin
              rbuf[7:0] <= ctl_q;
            end
            3'd3, 3'd4: begin
              is_adr <= (host_ofs == 3'd3);
              is_wr  <= host_wr;
              idx    <= '0;
              last   <= IW'(nb_req - 3'd1);
              wbuf   <= host_wdata;
              if (!host_wr) rbuf <= ones_fill(nb_req);
              if (host_wr ? wr_ok : rd_ok) st <= ST_STB;
            end
            default: if (!host_wr) rbuf[7:0] <= 8'hFF;
          endcase
        end
        ST_DIR: begin
          ctl_q   <= pend_ctl;
          ctl_upd <= 1'b1;
          st      <= ST_FIN;
        end
        ST_STB: begin
          if (per_rdy) begin
            if (!is_wr) rbuf <= rmerged;
            st <= ST_REL;
          end else if (expired) begin
            st <= ST_FIN;
          end
        end
        ST_REL: begin
          if (!per_rdy) begin
            if (idx == last) st <= ST_FIN;
            else begin
              idx <= idx + 1'b1;
              st  <= ST_STB;
            end
          end else if (expired) begin
            st <= ST_FIN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tmo_q <= 1'b0;
    else if (tmo_evt) tmo_q <= 1'b1;
    else if (clr_evt) tmo_q <= 1'b0;
  end

  assign host_rdy   = (st == ST_IDLE);
  assign host_done  = (st == ST_FIN);
  assign host_rdata = rbuf;
  assign dreg_o     = dreg_q;
  assign ctl_o      = ctl_q;
  assign adr_stb_n  = !(stb_on && is_adr);
  assign dat_stb_n  = !(stb_on && !is_adr);
  assign bus_wr_n   = !(xfer && is_wr);
  assign bus_oe     = xfer && is_wr;
endmodule

// File: rtl/epp_bridge_chk.sv
module epp_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_rdy,
  input logic       host_done,
  input logic       adr_stb_n,
  input logic       dat_stb_n,
  input logic       bus_wr_n,
  input logic       per_rdy,
  input logic [7:0] ctl_o,
  input logic       dir_upd,
  input logic       ctl_upd,
  input logic       tmo_q,
  input logic       tmo_evt,
  input logic       clr_evt
);
  logic stb_idle;
  assign stb_idle = adr_stb_n && dat_stb_n;

  a_r2_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stb_idle) && !bus_wr_n) |-> ((ctl_o & 8'h2F) == 8'h04));

  a_r3_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stb_idle) && bus_wr_n) |-> ((ctl_o & 8'h2F) == 8'h24));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adr_stb_n && !dat_stb_n));

  a_r6_release_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_idle) |-> ($past(per_rdy) || $past(tmo_evt)));

  a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> tmo_q);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !clr_evt) |=> tmo_q);

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !tmo_evt) |=> !tmo_q);

  a_r11_dir_before_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    dir_upd |=> ctl_upd);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  a_r12_busy_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_idle |-> !host_rdy);
endmodule

bind epp_bridge epp_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_rdy(host_rdy), .host_done(host_done),
  .adr_stb_n(adr_stb_n), .dat_stb_n(dat_stb_n), .bus_wr_n(bus_wr_n),
  .per_rdy(per_rdy), .ctl_o(ctl_o), .dir_upd(dir_upd), .ctl_upd(ctl_upd),
  .tmo_q(tmo_q), .tmo_evt(tmo_evt), .clr_evt(clr_evt)
);

// File: tb/epp_bridge_tb_top.sv
module epp_bridge_tb_top;
  localparam int TMO  = 16;
  localparam int RDLY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_ofs = '0;
  logic [1:0]  host_sz = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rdy, host_done;
  logic [31:0] host_rdata;
  logic [7:1]  stat_pins = 7'h55;
  logic [7:0]  dreg_o, ctl_o, bus_dout;
  logic        dreg_upd, ctl_upd, dir_o, dir_upd;
  logic        adr_stb_n, dat_stb_n, bus_wr_n, bus_oe;
  logic [7:0]  bus_din = 8'h00;
  logic        per_rdy = 1'b0;

  always #2 clk = ~clk;

  epp_bridge #(.TMO_CYC(TMO)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // peripheral model and event log
  int   log_n = 0;
  logic log_adr[0:1023];
  logic log_wrn[0:1023];
  logic log_oe[0:1023];
  logic [7:0] log_d[0:1023];
  int   resp_limit = 1 << 30;
  bit   hold_high = 0, tmo_mode = 0;
  int   viol = 0, dly = 0;
  bit   act_prev = 0;
  int   cyc = 0, dir_at = -1, ctl_at = -1, n_dupd = 0, n_cupd = 0;
  int   cur = 0;

  always @(negedge clk) begin
    bit act;
    cyc++;
    if (dreg_upd) n_dupd++;
    if (dir_upd) dir_at = cyc;
    if (ctl_upd) begin ctl_at = cyc; n_cupd++; end
    act = !adr_stb_n || !dat_stb_n;
    if (act && !act_prev) begin
      if (per_rdy) viol++;
      cur = log_n;
      log_adr[log_n % 1024] = !adr_stb_n;
      log_wrn[log_n % 1024] = bus_wr_n;
      log_oe[log_n % 1024]  = bus_oe;
      log_d[log_n % 1024]   = bus_dout;
      bus_din = 8'(8'hA0 + log_n);
      log_n++;
    end
    if (!act && act_prev && !per_rdy && !tmo_mode) viol++;
    if (act != act_prev) dly = 0; else dly++;
    if (act && cur < resp_limit && dly >= RDLY) per_rdy = 1'b1;
    if (!act && !hold_high && dly >= RDLY) per_rdy = 1'b0;
    act_prev = act;
  end

  task automatic acc(input bit wr, input logic [2:0] ofs, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_ofs = ofs; host_sz = sz; host_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0;
    lat = 1;
    while (!host_done) begin @(negedge clk); lat++; end
    rd = host_rdata;
    chk(!host_rdy, "R12 rdy low at done", 32'(host_rdy), 0);
    @(negedge clk);
    chk(!host_done && host_rdy, "R12 done single pulse", {30'd0, host_done, host_rdy}, 32'h1);
  endtask

  function automatic int nb_of(input logic [1:0] sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] rd, exp;
    int lat, n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(host_rdy && adr_stb_n && dat_stb_n, "R1 idle after reset",
        {29'd0, host_rdy, adr_stb_n, dat_stb_n}, 32'h7);
    acc(0, 3'd2, 0, 0, rd, lat);  chk(rd == 32'hCC, "R1 control reset", rd, 32'hCC);
    acc(0, 3'd1, 0, 0, rd, lat);  chk(rd == 32'hAA, "R1 R8 status reset", rd, 32'hAA);
    acc(0, 3'd0, 0, 0, rd, lat);  chk(rd == 32'hFF, "R1 data reset", rd, 32'hFF);

    // R3 gated reads return ones at width; R2 gated writes do nothing
    for (int s = 0; s < 4; s++) begin
      n0 = log_n;
      acc(0, 3'd4, 2'(s), 0, rd, lat);
      exp = (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
      chk(rd == exp && log_n == n0, "R3 gated read ones", rd, exp);
      acc(1, 3'd3, 2'(s), 32'h12, rd, lat);
      acc(1, 3'd4, 2'(s), 32'h34, rd, lat);
      chk(log_n == n0, "R2 gated write dropped", log_n - n0, 0);
    end

    // R9 redundant data writes
    acc(1, 3'd0, 0, 32'h3C, rd, lat);
    chk(n_dupd == 1 && dreg_o == 8'h3C, "R9 data update", {n_dupd[23:0], dreg_o}, 32'h13C);
    acc(1, 3'd0, 0, 32'h13C, rd, lat);
    chk(n_dupd == 1, "R9 equal data no pulse", n_dupd, 1);

    // R10 forced bits and redundant control
    acc(1, 3'd2, 0, 32'h04, rd, lat);
    chk(ctl_o == 8'hC4 && n_cupd == 1, "R10 control forced", ctl_o, 8'hC4);
    acc(1, 3'd2, 0, 32'hC4, rd, lat);
    acc(1, 3'd2, 0, 32'h44, rd, lat);
    chk(n_cupd == 1, "R10 equal control no pulse", n_cupd, 1);

    // R11 direction notice precedes control
    acc(1, 3'd2, 0, 32'h24, rd, lat);
    chk(ctl_at == dir_at + 1 && dir_o, "R11 dir then control", ctl_at - dir_at, 1);
    chk(ctl_o == 8'hE4, "R11 control applied", ctl_o, 8'hE4);

    // R2 R3 exhaustive mode sweep
    for (int v = 0; v < 64; v++) begin
      bit ew, er;
      ew = ((v & 8'h2F) == 8'h04);
      er = ((v & 8'h2F) == 8'h24);
      acc(1, 3'd2, 0, 32'(v), rd, lat);
      n0 = log_n;
      acc(1, 3'd4, 0, 32'(v), rd, lat);
      chk((log_n - n0) == int'(ew), "R2 write gate sweep", log_n - n0, 32'(ew));
      n0 = log_n;
      acc(0, 3'd4, 0, 0, rd, lat);
      chk((log_n - n0) == int'(er), "R3 read gate sweep", log_n - n0, 32'(er));
      exp = er ? 32'(8'(8'hA0 + n0)) : 32'hFF;
      chk(rd == exp, "R3 read value sweep", rd, exp);
    end

    // R4 R5 R6 writes
    acc(1, 3'd2, 0, 32'h04, rd, lat);
    for (int s = 0; s < 4; s++) begin
      logic [31:0] d;
      d = 32'h1122_3344 + 32'h0101_0101 * s;
      n0 = log_n;
      acc(1, 3'd3, 2'(s), d, rd, lat);
      chk(log_n - n0 == 1 && log_adr[n0] && !log_wrn[n0] && log_oe[n0] && log_d[n0] == d[7:0],
          "R4 address write one byte", {log_n - n0, log_d[n0]}, {24'd1, d[7:0]});
      n0 = log_n;
      acc(1, 3'd4, 2'(s), d, rd, lat);
      chk(log_n - n0 == nb_of(2'(s)), "R5 write byte count", log_n - n0, nb_of(2'(s)));
      for (int i = 0; i < nb_of(2'(s)); i++)
        chk(!log_adr[n0+i] && !log_wrn[n0+i] && log_d[n0+i] == 8'(d >> (8*i)),
            "R5 R6 write byte order", log_d[n0+i], 8'(d >> (8*i)));
    end

    // R4 R5 R6 reads
    acc(1, 3'd2, 0, 32'h24, rd, lat);
    for (int s = 0; s < 4; s++) begin
      n0 = log_n;
      acc(0, 3'd3, 2'(s), 0, rd, lat);
      chk(log_n - n0 == 1 && log_adr[n0] && log_wrn[n0] && !log_oe[n0] && rd == 32'(8'(8'hA0 + n0)),
          "R4 R6 address read", rd, 32'(8'(8'hA0 + n0)));
      n0 = log_n;
      acc(0, 3'd4, 2'(s), 0, rd, lat);
      exp = '0;
      for (int i = 0; i < nb_of(2'(s)); i++) exp[8*i +: 8] = 8'(8'hA0 + n0 + i);
      chk(rd == exp && log_n - n0 == nb_of(2'(s)), "R5 read assembly", rd, exp);
    end
    chk(viol == 0, "R6 handshake order", viol, 0);

    // R7 strobe-phase timeout on read, partial capture
    tmo_mode = 1;
    n0 = log_n;
    resp_limit = n0 + 1;
    acc(0, 3'd4, 2'd2, 0, rd, lat);
    exp = {24'hFFFFFF, 8'(8'hA0 + n0)};
    chk(rd == exp, "R7 partial read fill", rd, exp);
    chk(log_n - n0 == 2, "R7 tail bytes skipped", log_n - n0, 2);
    acc(0, 3'd1, 0, 0, rd, lat);
    chk(rd[0] == 1'b1, "R7 R8 flag set", rd, 32'hAB);
    acc(1, 3'd1, 0, 32'hFE, rd, lat);
    acc(0, 3'd1, 0, 0, rd, lat);
    chk(rd == 32'hAB, "R8 bit0 zero keeps flag", rd, 32'hAB);
    acc(1, 3'd1, 0, 32'h01, rd, lat);
    acc(0, 3'd1, 0, 0, rd, lat);
    chk(rd == 32'hAA, "R8 clear flag", rd, 32'hAA);

    // R7 abort latency with no answer at all
    acc(1, 3'd2, 0, 32'h04, rd, lat);
    resp_limit = log_n;
    n0 = log_n;
    acc(1, 3'd4, 2'd1, 32'hBEEF, rd, lat);
    chk(lat == TMO + 1, "R7 abort latency", lat, TMO + 1);
    chk(log_n - n0 == 1, "R7 write aborted after first byte", log_n - n0, 1);

    // R7 release-phase timeout
    acc(1, 3'd1, 0, 32'h01, rd, lat);
    resp_limit = 1 << 30;
    hold_high = 1;
    n0 = log_n;
    acc(1, 3'd4, 2'd1, 32'hCAFE, rd, lat);
    acc(0, 3'd1, 0, 0, rd, lat);
    chk(rd[0] && log_n - n0 == 1, "R7 release phase timeout", {rd[7:0], 8'(log_n - n0)}, 16'hAB01);
    hold_high = 0;
    repeat (RDLY + 3) @(negedge clk);
    tmo_mode = 0;

    finish_run();
  end
endmodule